// File: doc/BRIEF.md
# Soft Mute Ramp Controller

This block scales a stream of signed stereo audio samples by a digital gain that moves in 1 dB steps, one step per sample, between unity and silence. An active-low mute request input, brought into the block's clock domain through a two-stage synchronizer, selects the direction. While the request is asserted (low), the gain falls one step on every sample strobe until it reaches silence. While it is released (high), the gain climbs back to unity. A reversal part-way through a ramp turns the ramp around from the step it has reached.

The gain is held as a step index from 0 (unity) to 104 (exact zero). The index addresses a table of multipliers spaced 1 dB apart. Each sample is multiplied by the selected multiplier, rounded and clamped back to the input width. Separately, a zero-data detector counts consecutive frames in which both channels are zero and raises a hard-mute flag once the run is long enough. Both flags are meant to drive an analog mute stage that lies outside this block.

Top module: `soft_mute_ramp`

## Requirements
- R1: After reset the step index is 0 (unity gain), all outputs are 0, and `ramp_muted` and `zero_mute` are low.
- R2: A sample strobe at rising edge t produces `out_valid` high for exactly the one cycle after edge t+1, with both scaled samples valid in that cycle; `out_valid` is low at all other times.
- R3: The output is (x*M[k] + 16384) >>> 15, clamped to the signed input range. Here x is the input sample, k is the step index in force at the strobe, and M[k] = round(32768 * 10^(-k/20)). At k = 0 the output equals the input.
- R4: While `mute_n` is low, each strobe raises the step index by one, and the index stops at 104. M[104] is 0, so a full ramp down takes 104 strobes and ends with zero output.
- R5: While `mute_n` is high, each strobe lowers the step index by one, and the index stops at 0. A full ramp up from silence takes 104 strobes.
- R6: If `mute_n` changes part-way through a ramp, the next strobe moves the index one step in the new direction from its current value, with no jump.
- R7: The step index and all outputs change only in response to a strobe. A change on `mute_n` with no strobe changes no output.
- R8: `ramp_muted` is high exactly while the step index is 104. It is updated at the same edge as the index.
- R9: `zero_mute` goes high at the strobe edge of the 1024th consecutive frame in which both samples are zero, and it stays high while such frames continue.
- R10: A frame with a non-zero sample on either channel clears `zero_mute` at its own strobe edge and restarts the count from zero.
- R11: A change on `mute_n` passes through two synchronizing flops. A strobe uses the new level only if the change was stable before the two edges that come before the strobe edge.
- R12: No scaled sample has a larger magnitude than the sample it came from.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | One-cycle strobe marking a stereo frame |
| in_left | input | 16 | Left sample, signed two's complement |
| in_right | input | 16 | Right sample, signed two's complement |
| mute_n | input | 1 | Mute request, low = ramp down, high = ramp up (asynchronous) |
| out_left | output | 16 | Scaled left sample |
| out_right | output | 16 | Scaled right sample |
| out_valid | output | 1 | Marks the cycle in which the scaled samples are new |
| ramp_muted | output | 1 | Gain ramp has reached silence |
| zero_mute | output | 1 | Long run of all-zero frames detected |

## Verification
The assertions assume that reset is held for at least one clock edge. They also assume that `smp_valid` pulses for a single cycle, with strobes at least two cycles apart, so that the two pipeline stages never overlap. The stimulus spaces strobes four cycles apart and holds `mute_n` for three idle cycles before the next strobe, so every strobe sees a settled request. Expected outputs come from the multiplier formula and a step-index model kept in the bench. The bench sweeps full ramps in both directions with several sample patterns, including both extremes of the signed range.

// File: rtl/smr_pkg.sv
package smr_pkg;
  localparam int SMR_DW    = 16;
  localparam int SMR_FRAC  = 15;
  localparam int SMR_STEPS = 104;
  localparam int SMR_ZLIM  = 1024;
  localparam int SMR_NCH   = 2;
  typedef enum logic [1:0] {CH_LEFT = 2'd0, CH_RIGHT = 2'd1} smr_ch_e;
endpackage

// File: rtl/smr_sync.sv
module smr_sync #(
  parameter int STAGES = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RST_VAL}};
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];

  // R11: output follows the input delayed by exactly STAGES edges
  assert_sync_delay_R11: assert property (@(posedge clk) disable iff (rst)
    $past(rst) || (q == $past(chain[STAGES-2])));
endmodule

// File: rtl/smr_gain_ctrl.sv
module smr_gain_ctrl #(
  parameter int STEPS = 104,
  localparam int IW = $clog2(STEPS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  input  logic          down,
  output logic [IW-1:0] idx,
  output logic          floor_hit
);
  localparam logic [IW-1:0] TOP = IW'(STEPS);

  logic [IW-1:0] idx_nx;

  always_comb begin
    idx_nx = idx;
    if (step) begin
      if (down && idx != TOP)       idx_nx = idx + 1'b1;
      else if (!down && idx != '0)  idx_nx = idx - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx       <= '0;
      floor_hit <= 1'b0;
    end else begin
      idx       <= idx_nx;
      floor_hit <= (idx_nx == TOP);
    end
  end

  // R4/R5: index never leaves its range
  assert_idx_range_R4: assert property (@(posedge clk) disable iff (rst)
    idx <= TOP);
  // R6: index moves at most one step per edge (no jumps)
  assert_no_jump_R6: assert property (@(posedge clk) disable iff (rst)
    (idx == $past(idx)) || (idx == $past(idx) + 1'b1) || (idx + 1'b1 == $past(idx)));
  // R7: index is frozen without a strobe
  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(idx));
endmodule

// File: rtl/smr_gain_rom.sv
module smr_gain_rom #(
  parameter int STEPS = 104,
  parameter int FRAC  = 15,
  localparam int IW = $clog2(STEPS + 1),
  localparam int GW = FRAC + 1
) (
  input  logic          clk,
  input  logic          rd_en,
  input  logic [IW-1:0] addr,
  output logic [GW-1:0] q
);
  logic [GW-1:0] mem [0:STEPS];

  initial begin
    for (int k = 0; k <= STEPS; k++) begin
      if (k == STEPS) mem[k] = '0;
      else mem[k] = GW'($rtoi(real'(1 << FRAC) * (10.0 ** (-real'(k) / 20.0)) + 0.5));
    end
  end

  always_ff @(posedge clk) begin
    if (rd_en) q <= mem[addr];
  end
endmodule

// File: rtl/smr_scaler.sv
module smr_scaler #(
  parameter int DW   = 16,
  parameter int FRAC = 15,
  localparam int GW = FRAC + 1,
  localparam int PW = DW + GW + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cap,
  input  logic signed [DW-1:0] x_in,
  input  logic                 mul_en,
  input  logic        [GW-1:0] gain,
  output logic signed [DW-1:0] y
);
  localparam logic signed [PW-1:0] HALF = PW'(1) <<< (FRAC - 1);
  localparam logic signed [PW-1:0] MAXV = PW'((2 ** (DW - 1)) - 1);
  localparam logic signed [PW-1:0] MINV = -PW'(2 ** (DW - 1));

  logic signed [DW-1:0] x_q;
  logic signed [PW-1:0] prod, rnd;
  logic signed [DW-1:0] sat;

  always_comb begin
    prod = PW'(x_q) * PW'($signed({1'b0, gain}));
    rnd  = (prod + HALF) >>> FRAC;
    if (rnd > MAXV)      sat = MAXV[DW-1:0];
    else if (rnd < MINV) sat = MINV[DW-1:0];
    else                 sat = rnd[DW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      x_q <= '0;
      y   <= '0;
    end else begin
      if (cap)    x_q <= x_in;
      if (mul_en) y   <= sat;
    end
  end

  function automatic logic [DW:0] mag(input logic signed [DW-1:0] v);
    return v[DW-1] ? (DW+1)'(-$signed({v[DW-1], v})) : (DW+1)'(v);
  endfunction

  // R12: scaled magnitude never exceeds the source magnitude
  assert_no_gain_R12: assert property (@(posedge clk) disable iff (rst)
    mul_en |=> mag(y) <= mag($past(x_q)));
endmodule

// File: rtl/smr_zero_det.sv
module smr_zero_det #(
  parameter int ZLIM = 1024,
  localparam int CW = $clog2(ZLIM + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic frame,
  input  logic all_zero,
  output logic hard_mute
);
  localparam logic [CW-1:0] LIM = CW'(ZLIM);
  logic [CW-1:0] run;

  always_ff @(posedge clk) begin
    if (rst) begin
      run       <= '0;
      hard_mute <= 1'b0;
    end else if (frame) begin
      if (!all_zero) begin
        run       <= '0;
        hard_mute <= 1'b0;
      end else if (run != LIM) begin
        run       <= run + 1'b1;
        hard_mute <= (run + 1'b1 == LIM);
      end
    end
  end

  // R10: a non-zero frame clears the flag at its own edge
  assert_clear_R10: assert property (@(posedge clk) disable iff (rst)
    (frame && !all_zero) |=> !hard_mute);
  // R9: the flag can only rise at a frame edge
  assert_rise_on_frame_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(hard_mute) |-> $past(frame) && $past(all_zero));
endmodule

// File: rtl/soft_mute_ramp.sv
module soft_mute_ramp
  import smr_pkg::*;
#(
  parameter int DW    = SMR_DW,
  parameter int FRAC  = SMR_FRAC,
  parameter int STEPS = SMR_STEPS,
  parameter int ZLIM  = SMR_ZLIM
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 smp_valid,
  input  logic signed [DW-1:0] in_left,
  input  logic signed [DW-1:0] in_right,
  input  logic                 mute_n,
  output logic signed [DW-1:0] out_left,
  output logic signed [DW-1:0] out_right,
  output logic                 out_valid,
  output logic                 ramp_muted,
  output logic                 zero_mute
);
  localparam int IW = $clog2(STEPS + 1);
  localparam int GW = FRAC + 1;

  logic          req_n_s;
  logic [IW-1:0] step_idx;
  logic [GW-1:0] gain_q;
  logic          mul_v;
  logic signed [DW-1:0] ch_in  [SMR_NCH];
  logic signed [DW-1:0] ch_out [SMR_NCH];

  smr_sync #(.STAGES(2), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst(rst), .d(mute_n), .q(req_n_s));

  smr_gain_ctrl #(.STEPS(STEPS)) u_ctrl (
    .clk(clk), .rst(rst), .step(smp_valid), .down(!req_n_s),
    .idx(step_idx), .floor_hit(ramp_muted));

  smr_gain_rom #(.STEPS(STEPS), .FRAC(FRAC)) u_rom (
    .clk(clk), .rd_en(smp_valid), .addr(step_idx), .q(gain_q));

  assign ch_in[CH_LEFT]  = in_left;
  assign ch_in[CH_RIGHT] = in_right;

  for (genvar c = 0; c < SMR_NCH; c++) begin : g_ch
    smr_scaler #(.DW(DW), .FRAC(FRAC)) u_scl (
      .clk(clk), .rst(rst), .cap(smp_valid), .x_in(ch_in[c]),
      .mul_en(mul_v), .gain(gain_q), .y(ch_out[c]));
  end

  assign out_left  = ch_out[CH_LEFT];
  assign out_right = ch_out[CH_RIGHT];

  always_ff @(posedge clk) begin
    if (rst) begin
      mul_v     <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      mul_v     <= smp_valid;
      out_valid <= mul_v;
    end
  end

  smr_zero_det #(.ZLIM(ZLIM)) u_zdet (
    .clk(clk), .rst(rst), .frame(smp_valid),
    .all_zero((in_left == '0) && (in_right == '0)), .hard_mute(zero_mute));

  // R2: output marker trails the strobe by two edges
  assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
    smp_valid |=> ##1 out_valid);
  assert_no_spurious_R2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(mul_v));
  // R7: outputs hold between results
  assert_out_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !mul_v |=> $stable(out_left) && $stable(out_right));
endmodule

// File: tb/sim_soft_mute_ramp.sv
module sim_soft_mute_ramp;
  localparam int STEPS = 104;
  localparam int ZLIM  = 1024;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic smp_valid = 1'b0;
  logic signed [15:0] in_left = '0, in_right = '0;
  logic mute_n = 1'b1;
  logic signed [15:0] out_left, out_right;
  logic out_valid, ramp_muted, zero_mute;

  int total = 0, bad = 0, eidx = 0;
  bit done = 0;

  always #5 clk = ~clk;

  soft_mute_ramp u0 (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .in_left(in_left),
    .in_right(in_right), .mute_n(mute_n), .out_left(out_left),
    .out_right(out_right), .out_valid(out_valid), .ramp_muted(ramp_muted),
    .zero_mute(zero_mute));

  function automatic longint mult(input int k);
    if (k >= STEPS) return 0;
    return longint'($rtoi(32768.0 * (10.0 ** (-real'(k) / 20.0)) + 0.5));
  endfunction

  function automatic logic signed [15:0] scale(input logic signed [15:0] x, input int k);
    longint r;
    r = (longint'(x) * mult(k) + 16384) >>> 15;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return 16'(r);
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_mute(input logic v);
    @(negedge clk); mute_n = v;
    repeat (3) @(negedge clk);
  endtask

  // one frame: strobe, result checked after edge t+1, model stepped
  task automatic frame(input logic signed [15:0] l, input logic signed [15:0] r,
                       input string req);
    logic signed [15:0] el, er;
    el = scale(l, eidx); er = scale(r, eidx);
    if (!mute_n) eidx = (eidx < STEPS) ? eidx + 1 : STEPS;
    else         eidx = (eidx > 0) ? eidx - 1 : 0;
    @(negedge clk); smp_valid = 1'b1; in_left = l; in_right = r;
    @(negedge clk); smp_valid = 1'b0;
    chk({req, " R2 early"}, out_valid, 0);
    @(negedge clk);
    chk({req, " R2 valid"}, out_valid, 1);
    chk({req, " R3 left"}, out_left, el);
    chk({req, " R3 right"}, out_right, er);
    chk({req, " R8 muted"}, ramp_muted, eidx == STEPS);
    @(negedge clk);
    chk({req, " R2 pulse"}, out_valid, 0);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 out_left", out_left, 0);
    chk("R1 out_right", out_right, 0);
    chk("R1 valid", out_valid, 0);
    chk("R1 muted", ramp_muted, 0);
    chk("R1 zero_mute", zero_mute, 0);

    // R3 unity gain over several patterns and extremes
    frame(16'sd32767, -16'sd32768, "R3 unity ext");
    frame(16'sd1, -16'sd1, "R3 unity small");
    frame(16'sh1234, -16'sh4321, "R3 unity mix");

    // R7 / R11: request edge without strobe changes nothing
    @(negedge clk); mute_n = 1'b0;
    repeat (10) @(negedge clk);
    chk("R7 no strobe muted", ramp_muted, 0);
    chk("R7 no strobe out", out_left, 16'sh1234);

    // R4 full ramp down, sweeping sample patterns
    for (int k = 0; k < STEPS; k++) begin
      frame(16'(k * 613 - 32000), 16'(32767 - k * 311), "R4 down");
      if (k == STEPS - 2) chk("R4 not yet muted", ramp_muted, 0);
    end
    chk("R4 muted after 104", ramp_muted, 1);
    frame(16'sd32767, -16'sd32768, "R4 silent");
    chk("R4 zero out", out_left, 0);

    // R5 full ramp up
    set_mute(1'b1);
    for (int k = 0; k < STEPS; k++)
      frame(-16'(k * 301 + 5), 16'(k * 257 - 13000), "R5 up");
    chk("R5 unity reached", eidx, 0);
    frame(16'sd20000, -16'sd20000, "R5 unity out");
    chk("R5 unity exact", out_left, 16'sd20000);

    // R6 reversal mid ramp
    set_mute(1'b0);
    for (int k = 0; k < 50; k++) frame(16'sd30000, -16'sd30001, "R6 down part");
    set_mute(1'b1);
    for (int k = 0; k < 10; k++) frame(16'sd30000, -16'sd30001, "R6 reversed");
    set_mute(1'b0);
    for (int k = 0; k < 70; k++) frame(-16'sd12345, 16'sd777, "R6 down again");

    // R11 late change: change one cycle before strobe is not yet seen
    set_mute(1'b1);
    for (int k = 0; k < STEPS; k++) frame(16'sd100, 16'sd100, "R11 prep");
    @(negedge clk); mute_n = 1'b0; smp_valid = 1'b1; in_left = 16'sd32767; in_right = 16'sd32767;
    @(negedge clk); smp_valid = 1'b0;
    @(negedge clk);
    chk("R11 unsynced level ignored", out_left, 16'sd32767);
    chk("R11 idx still 0", ramp_muted, 0);
    @(negedge clk);
    eidx = 0;
    frame(16'sd32767, 16'sd0, "R11 now seen");
    chk("R11 step taken", out_left, 16'sd32767);
    frame(16'sd32767, 16'sd0, "R11 one step");
    set_mute(1'b1);
    frame(16'sd1000, 16'sd1000, "R11 back");
    frame(16'sd1000, 16'sd1000, "R11 back2");

    // R9 zero-data detection
    for (int k = 0; k < ZLIM - 1; k++) frame(16'sd0, 16'sd0, "R9 run");
    chk("R9 not before limit", zero_mute, 0);
    frame(16'sd0, 16'sd0, "R9 limit");
    chk("R9 set at limit", zero_mute, 1);
    frame(16'sd0, 16'sd0, "R9 hold");
    chk("R9 held", zero_mute, 1);
    // R10 non-zero left clears, then count restarts
    frame(16'sd1, 16'sd0, "R10 left");
    chk("R10 cleared left", zero_mute, 0);
    for (int k = 0; k < ZLIM - 1; k++) frame(16'sd0, 16'sd0, "R10 rerun");
    chk("R10 restart not yet", zero_mute, 0);
    frame(16'sd0, -16'sd1, "R10 right");
    chk("R10 cleared right", zero_mute, 0);
    for (int k = 0; k < ZLIM; k++) frame(16'sd0, 16'sd0, "R10 full");
    chk("R10 set again", zero_mute, 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule